// File: doc/BRIEF.md
# Pulse Width Measurement Timer Channel

This block is one 16-bit timer channel that measures how long an input pin stays high, or how long it stays low. A start strobe arms the channel. The channel then waits for the edge that begins the selected level. On that edge it clears its counter and counts up once per operating-clock tick. On the edge that ends the level it copies the count into a capture register, updates an overflow flag and sends a one-cycle interrupt pulse. The counter then freezes until the next starting edge, and the cycle repeats for as long as the channel stays enabled.

A stop strobe disables the channel. After a stop, the counter and the overflow flag keep their values. The pin passes through a two-stage synchronizer. An optional glitch filter can then be switched in before edge detection. The count, the captured value, the enable status and the overflow flag are all visible on output ports at every cycle.

Top module: `pulse_width_timer`

## Requirements
- R1: With `stop_trg` low, a `start_trg` pulse sets `chan_en` one cycle later. The channel then waits for a start edge, and `cnt_q` does not change until that edge is seen.
- R2: A start edge clears `cnt_q` to 0 and clears the measurement's overflow record. After that, `cnt_q` increments by one on every tick until the capture edge arrives.
- R3: A capture edge copies `cnt_q` into `cap_q` and raises `irq` for exactly one clock cycle. While `irq` is high, `cap_q` equals `cnt_q`.
- R4: At each capture, `ovf_flag` becomes 1 if the counter wrapped from 0xFFFF to 0x0000 after the latest start edge, and 0 otherwise. `ovf_flag` changes only in a capture cycle.
- R5: After a capture, `cnt_q` holds its value until the next start edge. A later start edge begins a new measurement.
- R6: A `stop_trg` pulse clears `chan_en`. While `chan_en` is 0, `cnt_q`, `cap_q` and `ovf_flag` do not change, and pin edges produce no `irq`.
- R7: When `lvl_sel`=0 the channel measures high width: the rising edge starts and the falling edge captures. When `lvl_sel`=1 it measures low width: the falling edge starts and the rising edge captures. If the pin is held at one level for N ticks and tick is high on every cycle, the result is `cap_q` = N-1.
- R8: When `filt_en`=1, a new pin level is accepted only after two consecutive tick samples agree, so a pulse only one tick long produces no edge. When `filt_en`=0, every tick sample is accepted directly.
- R9: If `start_trg` and `stop_trg` are high in the same cycle, the stop wins and `chan_en` is 0 on the next cycle.
- R10: When `tick` is low, the filter, the edge detector and the counter all hold their values. The pin always passes through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Operating-clock enable from the prescaler |
| pin_in | input | 1 | Pin being measured (asynchronous) |
| filt_en | input | 1 | Enables the glitch filter |
| lvl_sel | input | 1 | 0 measures high width, 1 measures low width |
| start_trg | input | 1 | Arm strobe, one cycle |
| stop_trg | input | 1 | Disable strobe, one cycle |
| cnt_q | output | 16 | Live counter value |
| cap_q | output | 16 | Last captured width |
| chan_en | output | 1 | Channel-enable status |
| ovf_flag | output | 1 | Overflow status of the last capture |
| irq | output | 1 | Capture interrupt pulse |

## Verification
A pin change reaches the filtered level only after the two synchronizer flops and one tick sample. Edges are acted on at the following tick. The counter, the capture register, `irq` and `ovf_flag` therefore change at the edge that closes that tick cycle. Triggers change `chan_en` at the next clock edge, whether or not a tick is present. The bench runs a behavioural model at each rising edge with the same input values the design sees. It compares every output at the falling edge that follows, so no check depends on guessing the latency. Directed checks on widths, overflow, hold after stop and trigger priority are read off at fixed points after each stimulus has fully settled.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2
  } pwt_state_e;
endpackage

// File: rtl/pwt_in_cond.sv
module pwt_in_cond #(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_in,
  input  logic filt_en,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int WIN_W = (FILT_SAMPLES > 1) ? FILT_SAMPLES - 1 : 1;

  logic [SYNC_STAGES-1:0] sy_q;
  logic                   smp;
  logic [WIN_W-1:0]       win_q, win_d;
  logic                   lvl_q, lvl_d, lvl_dly_q, lvl_dly_d;
  logic                   agree;

  // synchronizer chain, generated from its depth
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= pin_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= {sy_q[SYNC_STAGES-2:0], pin_in};
      end
    end
  endgenerate

  assign smp   = sy_q[SYNC_STAGES-1];
  assign agree = (&{win_q, smp}) | ~(|{win_q, smp});

  always_comb begin
    win_d     = win_q;
    lvl_d     = lvl_q;
    lvl_dly_d = lvl_dly_q;
    if (tick) begin
      if (WIN_W > 1) win_d = {win_q[WIN_W-2:0], smp};
      else           win_d = smp;
      lvl_d     = filt_en ? (agree ? smp : lvl_q) : smp;
      lvl_dly_d = lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      lvl_q     <= 1'b0;
      lvl_dly_q <= 1'b0;
    end else begin
      win_q     <= win_d;
      lvl_q     <= lvl_d;
      lvl_dly_q <= lvl_dly_d;
    end
  end

  assign lvl  = lvl_q;
  assign rise = tick &  lvl_q & ~lvl_dly_q;
  assign fall = tick & ~lvl_q &  lvl_dly_q;

  // filter keeps the old level while the samples disagree
  p_filt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && tick && !agree) |=> $stable(lvl_q));

  // nothing in the conditioner moves without a tick
  p_cond_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(lvl_q) && $stable(lvl_dly_q)));
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_trg,
  input  logic stop_trg,
  input  logic lvl_sel,
  input  logic rise,
  input  logic fall,
  output logic clr,
  output logic inc,
  output logic cap,
  output logic en
);
  pwt_state_e st_q, st_d;
  logic       st_edge, cp_edge, trg_any;

  assign st_edge = lvl_sel ? fall : rise;
  assign cp_edge = lvl_sel ? rise : fall;
  assign trg_any = start_trg | stop_trg;

  always_comb begin
    st_d = st_q;
    clr  = 1'b0;
    inc  = 1'b0;
    cap  = 1'b0;
    if (stop_trg) begin
      st_d = ST_OFF;
    end else if (start_trg) begin
      st_d = ST_WAIT;
    end else begin
      unique case (st_q)
        ST_WAIT: if (st_edge) begin
          clr  = 1'b1;
          st_d = ST_MEAS;
        end
        ST_MEAS: if (cp_edge) begin
          cap  = 1'b1;
          st_d = ST_WAIT;
        end else if (tick) begin
          inc = 1'b1;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign en = (st_q != ST_OFF);

  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trg |=> !en);

  p_start_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trg && !stop_trg) |=> (en && st_q == ST_WAIT));

  p_trg_blocks_edges_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trg_any |-> !(clr || inc || cap));
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             cap,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             ovf_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d, cap_d;
  logic             ovf_d, irq_d, wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    cap_d  = cap_q;
    ovf_d  = ovf_q;
    wrap_d = wrap_q;
    irq_d  = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else if (cap) begin
      cap_d = cnt_q;
      ovf_d = wrap_q;
      irq_d = 1'b1;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_MAX) wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      ovf_q  <= 1'b0;
      wrap_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      ovf_q  <= ovf_d;
      wrap_q <= wrap_d;
      irq_q  <= irq_d;
    end
  end

  p_wrap_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q == CNT_MAX) |=> (wrap_q && cnt_q == '0));

  p_clear_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !wrap_q));
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pin_in,
  input  logic             filt_en,
  input  logic             lvl_sel,
  input  logic             start_trg,
  input  logic             stop_trg,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             chan_en,
  output logic             ovf_flag,
  output logic             irq
);
  logic lvl, rise, fall, clr, inc, cap;

  pwt_in_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_SAMPLES(FILT_SAMPLES)) u_cond (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in), .filt_en(filt_en),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  pwt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_trg(start_trg),
    .stop_trg(stop_trg), .lvl_sel(lvl_sel), .rise(rise), .fall(fall),
    .clr(clr), .inc(inc), .cap(cap), .en(chan_en)
  );

  pwt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .cap(cap),
    .cnt_q(cnt_q), .cap_q(cap_q), .ovf_q(ovf_flag), .irq_q(irq)
  );

  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_cap_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_q == cnt_q));

  p_ovf_at_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_flag) |-> irq);

  p_off_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> ($stable(cnt_q) && $stable(cap_q) && !irq));

  p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  p_hold_after_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> $stable(cnt_q));
endmodule

// File: tb/sim_pulse_width_timer.sv
module sim_pulse_width_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        pin_in = 1'b0;
  logic        filt_en = 1'b0;
  logic        lvl_sel = 1'b0;
  logic        start_trg = 1'b0;
  logic        stop_trg = 1'b0;
  logic [15:0] cnt_q, cap_q;
  logic        chan_en, ovf_flag, irq;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;
  int irq_seen = 0;

  always #10 clk = ~clk;

  pulse_width_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in), .filt_en(filt_en),
    .lvl_sel(lvl_sel), .start_trg(start_trg), .stop_trg(stop_trg),
    .cnt_q(cnt_q), .cap_q(cap_q), .chan_en(chan_en), .ovf_flag(ovf_flag), .irq(irq)
  );

  // behavioural reference: pin history queue, sample list, integer state
  bit pin_hist[$];
  bit samp_hist[$];
  bit m_lvl, m_lvl_old;
  int m_mode;            // 0 off, 1 waiting, 2 measuring
  int m_cnt, m_cap;
  bit m_wrap, m_ovf, m_irq;

  task automatic model_reset();
    pin_hist = '{0, 0};
    samp_hist = '{0};
    m_lvl = 0; m_lvl_old = 0; m_mode = 0;
    m_cnt = 0; m_cap = 0; m_wrap = 0; m_ovf = 0; m_irq = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit synced, up, down, begin_e, end_e;
      synced = pin_hist[0];
      pin_hist.push_back(pin_in);
      void'(pin_hist.pop_front());
      up   = tick &&  m_lvl && !m_lvl_old;
      down = tick && !m_lvl &&  m_lvl_old;
      begin_e = lvl_sel ? down : up;
      end_e   = lvl_sel ? up : down;
      m_irq = 0;
      if (stop_trg) m_mode = 0;
      else if (start_trg) m_mode = 1;
      else if (m_mode == 1 && begin_e) begin
        m_cnt = 0; m_wrap = 0; m_mode = 2;
      end else if (m_mode == 2 && end_e) begin
        m_cap = m_cnt; m_ovf = m_wrap; m_irq = 1; m_mode = 1;
      end else if (m_mode == 2 && tick) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 65536) begin m_cnt = 0; m_wrap = 1; end
      end
      if (tick) begin
        bit accept;
        accept = !filt_en || (samp_hist[0] == synced);
        m_lvl_old = m_lvl;
        if (accept) m_lvl = synced;
        samp_hist[0] = synced;
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      cmp("R2/R5 cnt_q", cnt_q, m_cnt);
      cmp("R3 cap_q", cap_q, m_cap);
      cmp("R3 irq", irq, m_irq);
      cmp("R4 ovf_flag", ovf_flag, m_ovf);
      cmp("R1/R6 chan_en", chan_en, (m_mode != 0) ? 1 : 0);
      if (irq) irq_seen++;
    end
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_trg = 1'b1; @(negedge clk); start_trg = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_trg = 1'b1; @(negedge clk); stop_trg = 1'b0;
  endtask

  task automatic hold_pin(bit v, int n);
    pin_in = v; wait_cyc(n);
  endtask

  initial begin
    int c0;
    wait_cyc(3);
    // reset state
    cmp("R1 reset chan_en", chan_en, 0);
    cmp("R3 reset cap_q", cap_q, 0);
    cmp("R4 reset ovf_flag", ovf_flag, 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1: armed but no edge -> counter idle
    pulse_start();
    cmp("R1 enable after start", chan_en, 1);
    wait_cyc(10);
    cmp("R1 no count before edge", cnt_q, 0);

    // R7 high width, tick every cycle, no filter: width 25 -> 24
    hold_pin(1, 25); hold_pin(0, 8);
    cmp("R7 high width", cap_q, 24);
    cmp("R4 no overflow", ovf_flag, 0);
    c0 = cnt_q;
    wait_cyc(10);
    cmp("R5 hold after capture", cnt_q, c0);

    // R5 repeat measurement
    hold_pin(1, 12); hold_pin(0, 8);
    cmp("R5 second measurement", cap_q, 11);

    // R7 low width
    lvl_sel = 1'b1;
    hold_pin(1, 10);
    hold_pin(0, 17); hold_pin(1, 8);
    cmp("R7 low width", cap_q, 16);

    // R8 filter: one-cycle glitch ignored, then real pulse
    lvl_sel = 1'b0; filt_en = 1'b1;
    hold_pin(0, 10);
    c0 = irq_seen;
    hold_pin(1, 1); hold_pin(0, 12);
    cmp("R8 glitch no irq", irq_seen, c0);
    hold_pin(1, 14); hold_pin(0, 10);
    cmp("R8 filtered width", cap_q, 13);

    // R10 sparse tick
    filt_en = 1'b0;
    for (int i = 0; i < 60; i++) begin
      tick = (i % 3 == 0);
      pin_in = (i >= 6 && i < 36);
      @(negedge clk);
    end
    tick = 1'b1;
    wait_cyc(10);
    cmp("R10 sparse tick width", cap_q, 9);

    // R6 stop mid-measurement holds state
    hold_pin(1, 30);
    pulse_stop();
    cmp("R6 chan_en cleared", chan_en, 0);
    c0 = cnt_q;
    hold_pin(0, 10); hold_pin(1, 10);
    cmp("R6 count held", cnt_q, c0);
    cmp("R6 cap held", cap_q, 9);

    // R9 same-cycle triggers
    start_trg = 1'b1; stop_trg = 1'b1; @(negedge clk);
    start_trg = 1'b0; stop_trg = 1'b0;
    cmp("R9 stop wins", chan_en, 0);

    // R4 overflow: 65546 ticks high -> capture 9 with flag
    hold_pin(0, 8);
    pulse_start();
    hold_pin(1, 65546); hold_pin(0, 8);
    cmp("R4 wrapped capture", cap_q, 9);
    cmp("R4 overflow set", ovf_flag, 1);
    hold_pin(1, 20); hold_pin(0, 8);
    cmp("R4 overflow cleared", ovf_flag, 0);
    cmp("R2 restart from zero", cap_q, 19);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule